// File: doc/BRIEF.md
# Programmable DMA Request Input Conditioner

This block takes four asynchronous DMA request lines, one for each channel that can be started from outside the chip. It retimes each line into the system clock domain and turns it into a request-pending flag for the channel arbiter. Each channel has its own 2-bit detection mode, which comes from a configuration register elsewhere. A level mode passes the retimed line straight through, as active-low or active-high. An edge mode catches a rising or falling transition and holds it until that channel's acknowledge clears it.

The arbiter samples `req_pend` and returns a one-cycle `ack` for the channel it serves. In the level modes the request drops when the requester releases its line, so `ack` has no effect. In the edge modes `ack` clears the held request. An edge that lands in the same cycle as `ack` is kept, so no request is lost. Writing a new mode for a channel removes any request that channel holds.

Top module: `dreq_detect`

## Requirements
- R1: Each request line passes through a two-flop synchronizer. A change on `req_in` reaches `req_pend` in a level mode after exactly two rising clock edges.
- R2: Channel n takes its mode from `mode[2n+1:2n]`: 00 active-low level, 01 active-high level, 10 rising edge, 11 falling edge. Code 00 is the value the configuration register is expected to hold after reset. After a synchronous active-low reset the synchronizers hold logic 1, the stored mode is 00, and `req_pend` is 0 on all channels while `req_in` is held high.
- R3: In mode 00, `req_pend` equals the inverse of the synchronized line, and `ack` has no effect on it.
- R4: In mode 01, `req_pend` equals the synchronized line, and `ack` has no effect on it.
- R5: In mode 10, a 0-to-1 transition of the synchronized line sets a pending flag one edge later. The flag stays set until a clock edge at which `ack` is high and no new edge is seen.
- R6: In mode 11, a 1-to-0 transition of the synchronized line sets the pending flag in the same way, and `ack` clears it in the same way.
- R7: When an edge is detected in the same cycle as `ack`, the flag is set or stays set.
- R8: A clock edge at which a channel's mode differs from its stored mode clears that channel's pending flag. A transition seen at that same edge is discarded.
- R9: Each channel's input, mode and acknowledge affect only that channel's `req_pend`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 4 | Asynchronous request lines, bit n for channel n |
| mode | input | 8 | Detection mode, two bits per channel |
| ack | input | 4 | Acknowledge from the arbiter, one bit per channel |
| req_pend | output | 4 | Request pending to the arbiter, one bit per channel |

## Verification
Random toggling of the request lines, mixed with random acknowledges and occasional mode rewrites, drives all four modes on all channels at once. Comparing each output to a cycle model separates level pass-through from edge capture, and it also shows whether an acknowledge clears a request or is ignored. Directed sequences then place a single transition to measure the two-edge latency. They also line up an edge exactly with an acknowledge to show which one wins, and change the mode while a request is held. Because the four channels run different modes side by side, any leak of one channel's state into another shows up as a mismatch.

// File: rtl/dreq_pkg.sv
// Shared types for the DMA request conditioner.
// Assumes: mode codes are decoded as written here by the configuration logic.
package dreq_pkg;
    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_mode_e;

    localparam int MODE_W = 2;
endpackage

// File: rtl/dreq_sync.sv
// Multi-flop synchronizer for one asynchronous line.
// Assumes: STAGES >= 2; the reset value is the idle level of the line.
module dreq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg[0] == $past(d)); // R1

    for (genvar k = 1; k < STAGES; k++) begin : g_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> stg[k] == $past(stg[k-1])); // R1
    end
endmodule

// File: rtl/dreq_chan.sv
// Detection stage for one channel: level pass-through or edge capture.
// Assumes: sync_lvl is already in the clk domain; ack is a one-cycle pulse.
module dreq_chan
    import dreq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_lvl,
    input  det_mode_e mode,
    input  logic      ack,
    output logic      pend
);
    logic      prev_q;
    logic      lat_q;
    det_mode_e mode_q;
    logic      is_edge;
    logic      edge_hit;
    logic      mode_chg;

    assign is_edge  = (mode == DET_RISE) || (mode == DET_FALL);
    assign mode_chg = (mode != mode_q);

    // Pick the transition direction the current mode watches for.
    always_comb begin
        if (mode == DET_RISE) edge_hit = sync_lvl & ~prev_q;
        else                  edge_hit = ~sync_lvl & prev_q;
    end

    // Remember the previous level and the last mode seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            mode_q <= DET_LOW;
        end else begin
            prev_q <= sync_lvl;
            mode_q <= mode;
        end
    end

    // Pending flag: mode change clears, edge sets, ack clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_q <= 1'b0;
        else if (mode_chg || !is_edge) lat_q <= 1'b0;
        else if (edge_hit)         lat_q <= 1'b1;
        else if (ack)              lat_q <= 1'b0;
    end

    // Drive the request from the level or from the flag.
    always_comb begin
        case (mode)
            DET_LOW:  pend = ~sync_lvl;
            DET_HIGH: pend = sync_lvl;
            default:  pend = lat_q;
        endcase
    end

    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && !mode_chg && edge_hit && ack) |=> lat_q); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && !mode_chg && !edge_hit && ack) |=> !lat_q); // R5
    AST_MODE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !lat_q); // R8
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && !mode_chg && lat_q && !ack) |=> lat_q); // R6
    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_edge) |=> !lat_q); // R3
endmodule

// File: rtl/dreq_detect.sv
// Top: per-channel synchronizer plus programmable detection for NUM_CH lines.
// Assumes: mode comes from a register; ack is produced by the arbiter.
module dreq_detect
    import dreq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int MODE_BITS  = NUM_CH * MODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    req_in,
    input  logic [MODE_BITS-1:0] mode,
    input  logic [NUM_CH-1:0]    ack,
    output logic [NUM_CH-1:0]    req_pend
);
    logic [NUM_CH-1:0] lvl;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dreq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (req_in[ch]),
            .q     (lvl[ch])
        );

        dreq_chan i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_lvl (lvl[ch]),
            .mode     (det_mode_e'(mode[ch*MODE_W +: MODE_W])),
            .ack      (ack[ch]),
            .pend     (req_pend[ch])
        );
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (req_pend & ~{NUM_CH{1'b0}}) == ({NUM_CH{1'b0}} | ~lvl & {NUM_CH{1'b0}})
                   || mode != '0 || req_pend == '0); // R2
endmodule

// File: tb/test_dreq_detect.sv
module test_dreq_detect;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   req_in;
    logic [2*N-1:0] mode;
    logic [N-1:0]   ack;
    logic [N-1:0]   req_pend;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dreq_detect i_dreq_detect (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .mode(mode), .ack(ack), .req_pend(req_pend)
    );

    // Cycle model built from the requirements.
    logic [N-1:0] m_s1, m_s2, m_prev, m_lat;
    logic [1:0]   m_mq [N];

    always @(posedge clk) begin
        for (int c = 0; c < N; c++) begin
            logic [1:0] md;
            logic       e;
            md = mode[2*c +: 2];
            if (!rst_n) begin
                m_s1[c] <= 1'b1; m_s2[c] <= 1'b1; m_prev[c] <= 1'b1;
                m_lat[c] <= 1'b0; m_mq[c] <= 2'b00;
            end else begin
                e = (md == 2'b10) ? (m_s2[c] & ~m_prev[c]) : (~m_s2[c] & m_prev[c]);
                m_s1[c] <= req_in[c];
                m_s2[c] <= m_s1[c];
                m_prev[c] <= m_s2[c];
                m_mq[c] <= md;
                if (md != m_mq[c] || md[1] == 1'b0) m_lat[c] <= 1'b0;
                else if (e)                        m_lat[c] <= 1'b1;
                else if (ack[c])                   m_lat[c] <= 1'b0;
            end
        end
    end

    function automatic logic exp_pend(int c);
        logic [1:0] md;
        md = mode[2*c +: 2];
        case (md)
            2'b00:   return ~m_s2[c];
            2'b01:   return m_s2[c];
            default: return m_lat[c];
        endcase
    endfunction

    function automatic string tag_of(int c);
        case (mode[2*c +: 2])
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp, int c);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d: req_pend=%b expected %b at %0t", tag, c, act, exp, $time);
        end
    endtask

    task automatic check_all_model(string tag);
        for (int c = 0; c < N; c++)
            check(tag == "" ? tag_of(c) : tag, req_pend[c], exp_pend(c), c);
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_in = '1; mode = '0; ack = '0;
        repeat (3) tick;
        rst_n = 1'b1;
        for (int c = 0; c < N; c++) check("R2", req_pend[c], 1'b0, c);
        tick;
        for (int c = 0; c < N; c++) check("R2", req_pend[c], 1'b0, c);

        // R1: single transition in high mode on channel 0
        mode = 8'b00_00_00_01;
        repeat (3) tick;
        req_in[0] = 1'b0;
        tick; tick;
        req_in[0] = 1'b1;
        tick;
        check("R1", req_pend[0], 1'b0, 0);
        tick;
        check("R1", req_pend[0], 1'b1, 0);
        // R4: ack ignored in level mode
        ack[0] = 1'b1; tick; ack[0] = 1'b0;
        check("R4", req_pend[0], 1'b1, 0);

        // R7: rising edge on ch2 lined up with ack
        mode = 8'b00_10_00_01;
        req_in[2] = 1'b0;
        repeat (4) tick;
        req_in[2] = 1'b1;
        tick; tick;
        ack[2] = 1'b1;
        tick;
        check("R7", req_pend[2], 1'b1, 2);
        tick;
        ack[2] = 1'b0;
        check("R5", req_pend[2], 1'b0, 2);
        // R9: other channels undisturbed by ch2 activity
        check("R9", req_pend[1], 1'b0, 1);
        check("R9", req_pend[0], 1'b1, 0);

        // R8: held falling-edge flag dropped by mode rewrite
        mode[5:4] = 2'b11;
        tick;
        req_in[2] = 1'b0;
        repeat (3) tick;
        check("R6", req_pend[2], 1'b1, 2);
        mode[5:4] = 2'b10;
        tick;
        check("R8", req_pend[2], 1'b0, 2);
        mode[5:4] = 2'b11;
        tick;
        check("R8", req_pend[2], 1'b0, 2);
        check_all_model("R9");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            req_in = N'($urandom);
            ack = N'($urandom) & N'($urandom);
            for (int c = 0; c < N; c++)
                if ($urandom_range(15) == 0) mode[2*c +: 2] = 2'($urandom);
            tick;
            check_all_model("");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule